// File: doc/BRIEF.md
# Reference Clock Input Selector

This block decides which of four reference clock inputs feeds a downstream phase-locked loop. Activity monitors outside the block provide one clock-present flag per input. The block returns the index of the chosen input and a flag that says whether that input is toggling. It also raises a holdover request or a free-run request when the chosen input is missing. Which of the two requests it raises depends on whether a good reference has ever been seen since reset. A one-cycle pulse marks each change of selection, so a downstream glitch-free mux can sequence the switch.

There are two ways to select an input. In manual mode the index comes from two select pins or from a register field, and a configuration bit chooses between them. In the automatic modes each input has a programmable priority. The block leaves an input that loses its clock and moves to the best input that still has one. In revertive mode it also returns to a better input once that input has been present for a programmable number of cycles. A zero-delay option sets input 3 aside as the loop feedback, so input 3 can no longer be chosen as a reference.

Software configures the block through a small write-only port with four 8-bit registers. A write takes effect on the clock edge where it is issued.

Top module: `refclk_selector`

## Requirements
- R1: Register 0 bits [1:0] set the switching mode: 00 is manual, 01 is automatic without reverting, 10 is automatic with reverting, and the reserved code 11 behaves as manual.
- R2: Register 1 bit 0 chooses where the manual selection comes from. A value of 0 (the reset value) means the select pins, and 1 means register 1 bits [2:1]. The source that is not chosen has no effect on the selection.
- R3: A selection code of 0, 1, 2 or 3 selects input 0, 1, 2 or 3. In manual mode the chosen index appears on sel_idx one clock edge after the code is presented.
- R4: Register 1 bit 5 enables zero-delay mode. In this mode input 3 is never newly selected, and a manual code of 3 leaves the current selection unchanged.
- R5: In zero-delay mode with register control, the code comes from register 1 bits [4:3] and register 1 bits [2:1] are ignored.
- R6: While the selected input has no clock present, holdover_req is 1 if any selected input has had a clock present since reset, and otherwise freerun_req is 1. Both follow clk_present in the same cycle, and both are 0 while the selected input is present.
- R7: Register 2 holds a 2-bit priority per input, with input i at bits [2i+1:2i]. A lower nonzero value ranks higher, ties go to the lower index, and priority 0 excludes the input from automatic selection.
- R8: In either automatic mode, when the current input is absent or excluded and another eligible input is present, the selection moves to the best eligible input on the next edge. If no input qualifies, the selection stays and holdover or free-run is requested.
- R9: In non-revertive automatic mode, the selection does not change while the current input is present and eligible.
- R10: In revertive mode, suppose an input has better priority than the current one and has been present for N consecutive cycles, where N is register 3 (reset value 4). The selection moves to it on edge N+1, counting from the first edge that sees it present.
- R11: Register writes take effect on the edge where cfg_we is sampled high, with cfg_addr choosing the register and cfg_wdata giving the value.
- R12: sel_valid equals the clock-present flag of the selected input. sel_change is high for exactly the one cycle after each edge that changes sel_idx. After reset sel_idx is 0 and sel_change is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| sel_pins | input | 2 | Select pins used when pin control is chosen |
| clk_present | input | 4 | Per-input clock-present flags from the activity monitors |
| sel_idx | output | 2 | Index of the selected input |
| sel_valid | output | 1 | Selected input currently has a clock |
| sel_change | output | 1 | One-cycle pulse after a selection change |
| holdover_req | output | 1 | Request holdover because the selected clock is missing |
| freerun_req | output | 1 | Request free-run because no good reference has been seen yet |

## Verification
Each result is due at a fixed number of edges after its stimulus. A pin change, or a loss of clock in automatic mode, shows on sel_idx one edge later. A register write needs two edges, one to store the value and one to act on it. A revert needs N+1 edges, so the bench checks that nothing has moved after N edges and that the move has happened one edge later. The holdover and free-run requests and sel_valid respond to clk_present in the same cycle, so the bench checks them a moment after changing the flags, before the next edge. Every stimulus is applied, and every output sampled, one time unit after a rising edge.

// File: rtl/refclk_selector.sv
module refclk_selector #(
  parameter int QW = 8,
  parameter logic [QW-1:0] QUAL_RST = QW'(4)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic [1:0] sel_pins,
  input  logic [3:0] clk_present,
  output logic [1:0] sel_idx,
  output logic       sel_valid,
  output logic       sel_change,
  output logic       holdover_req,
  output logic       freerun_req
);
  localparam logic [QW-1:0] QMAX = '1;
  localparam logic [1:0] M_NONREV = 2'b01;
  localparam logic [1:0] M_REV    = 2'b10;

  logic [1:0]    mode_q, rsel_q, zsel_q;
  logic          src_reg_q, zd_q;
  logic [7:0]    prio_q;
  logic [QW-1:0] qual_q;
  logic [1:0]    sel_q, next_sel;
  logic          chg_q, hist_q;
  logic [3:0]    elig, qual_ok;

  // R11 register write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      src_reg_q <= 1'b0;
      rsel_q    <= '0;
      zsel_q    <= '0;
      zd_q      <= 1'b0;
      prio_q    <= 8'h55;
      qual_q    <= QUAL_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: mode_q <= cfg_wdata[1:0];
        2'd1: begin
          src_reg_q <= cfg_wdata[0];
          rsel_q    <= cfg_wdata[2:1];
          zsel_q    <= cfg_wdata[4:3];
          zd_q      <= cfg_wdata[5];
        end
        2'd2: prio_q <= cfg_wdata;
        default: qual_q <= QW'(cfg_wdata);
      endcase
    end
  end

  for (genvar gi = 0; gi < 4; gi++) begin : g_in
    logic [QW-1:0] qcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qcnt_q <= '0;
      else if (!clk_present[gi]) qcnt_q <= '0;
      else if (qcnt_q != QMAX) qcnt_q <= qcnt_q + 1'b1;
    end
    assign elig[gi]    = clk_present[gi] && (prio_q[2*gi +: 2] != 2'd0) && !(zd_q && gi == 3);
    assign qual_ok[gi] = elig[gi] && (qcnt_q >= qual_q);
  end

  function automatic logic [2:0] best_of(input logic [3:0] cand, input logic [7:0] pr);
    logic [2:0] r;
    logic [1:0] bp;
    r  = '0;
    bp = '1;
    for (int i = 0; i < 4; i++) begin
      if (cand[i] && (!r[2] || pr[2*i +: 2] < bp)) begin
        r  = {1'b1, 2'(i)};
        bp = pr[2*i +: 2];
      end
    end
    return r;
  endfunction

  logic [2:0] auto_b, rev_b;
  logic [1:0] man_code, man_next, cur_prio, rev_prio;
  logic       cur_ok;

  assign auto_b   = best_of(elig, prio_q);
  assign rev_b    = best_of(qual_ok, prio_q);
  assign cur_ok   = elig[sel_q];
  assign cur_prio = prio_q[2*sel_q +: 2];
  assign rev_prio = prio_q[2*rev_b[1:0] +: 2];
  assign man_code = src_reg_q ? (zd_q ? zsel_q : rsel_q) : sel_pins;
  assign man_next = (zd_q && man_code == 2'd3) ? sel_q : man_code;

  always_comb begin
    next_sel = sel_q;
    case (mode_q)
      M_NONREV: if (!cur_ok && auto_b[2]) next_sel = auto_b[1:0];
      M_REV: begin
        if (!cur_ok && auto_b[2]) next_sel = auto_b[1:0];
        else if (cur_ok && rev_b[2] && rev_prio < cur_prio) next_sel = rev_b[1:0];
      end
      default: next_sel = man_next;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      chg_q  <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      sel_q  <= next_sel;
      chg_q  <= next_sel != sel_q;
      hist_q <= hist_q | clk_present[sel_q];
    end
  end

  assign sel_idx      = sel_q;
  assign sel_change   = chg_q;
  assign sel_valid    = clk_present[sel_q];
  assign holdover_req = !sel_valid && hist_q;
  assign freerun_req  = !sel_valid && !hist_q;

  p_change_marks_move_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change == (sel_idx != $past(sel_idx)));
  p_fb_never_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_change && $past(zd_q)) |-> sel_idx != 2'd3);
  p_nonrev_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q == M_NONREV && cur_ok) |-> !sel_change);
  p_loss_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past((mode_q == M_NONREV || mode_q == M_REV) && !cur_ok && (|elig)) |-> sel_change);
  p_revert_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_change && $past(mode_q == M_REV && cur_ok)) |-> ((($past(qual_ok) >> sel_idx) & 4'd1) != 4'd0));
  p_freerun_no_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
    freerun_req |-> !$past(sel_valid));
endmodule

// File: tb/refclk_selector_tb.sv
module refclk_selector_tb;
  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [1:0] cfg_addr = '0, sel_pins = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] clk_present = '0;
  logic [1:0] sel_idx;
  logic sel_valid, sel_change, holdover_req, freerun_req;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  refclk_selector u_dut (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .sel_pins,
    .clk_present, .sel_idx, .sel_valid, .sel_change, .holdover_req, .freerun_req);

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int prev;
    step(3);
    chk("R12 reset sel_idx", sel_idx, 0);
    chk("R12 reset sel_change", sel_change, 0);
    chk("R6 reset freerun_req", freerun_req, 1);
    chk("R6 reset holdover_req", holdover_req, 0);
    rst_n = 1;
    clk_present = 4'hF;
    step(1);
    chk("R12 sel_valid", sel_valid, 1);

    prev = 0;
    for (int c = 0; c < 4; c++) begin
      sel_pins = 2'(c);
      step(1);
      chk("R3 pin code", sel_idx, c);
      chk("R12 change pulse", sel_change, int'(c != prev));
      prev = c;
    end

    wr(2'd0, 8'h03);
    sel_pins = 2'd1;
    step(1);
    chk("R1 reserved mode acts manual", sel_idx, 1);

    wr(2'd1, 8'h05);
    step(1);
    chk("R2 register source", sel_idx, 2);
    sel_pins = 2'd3;
    step(1);
    chk("R2 pins ignored", sel_idx, 2);

    for (int c = 0; c < 4; c++) begin
      wr(2'd1, 8'((c << 1) | 1));
      step(1);
      chk("R3 R11 register code", sel_idx, c);
    end

    wr(2'd1, 8'h2F);
    step(1);
    chk("R5 zero-delay select field", sel_idx, 1);
    wr(2'd1, 8'h3F);
    step(1);
    chk("R4 reserved code keeps", sel_idx, 1);
    chk("R4 no change pulse", sel_change, 0);
    sel_pins = 2'd3;
    wr(2'd1, 8'h20);
    step(1);
    chk("R4 pin code 3 reserved", sel_idx, 1);
    sel_pins = 2'd2;
    step(1);
    chk("R4 pin code 2 in zero-delay", sel_idx, 2);

    clk_present = 4'b1011;
    #1;
    chk("R6 holdover_req", holdover_req, 1);
    chk("R6 freerun_req off", freerun_req, 0);
    chk("R12 sel_valid low", sel_valid, 0);
    clk_present = 4'hF;
    #1;
    chk("R6 requests clear", int'(holdover_req | freerun_req), 0);

    wr(2'd1, 8'h00);
    wr(2'd2, 8'h39);
    wr(2'd0, 8'h01);
    step(3);
    chk("R9 stays on valid input", sel_idx, 2);
    clk_present = 4'b1011;
    step(1);
    chk("R8 loss moves to best", sel_idx, 0);
    chk("R12 pulse on move", sel_change, 1);
    step(1);
    chk("R12 pulse one cycle", sel_change, 0);
    clk_present = 4'b1010;
    step(1);
    chk("R7 excluded input skipped", sel_idx, 1);
    clk_present = 4'b1011;
    step(10);
    chk("R9 no revert", sel_idx, 1);
    clk_present = 4'b1000;
    step(2);
    chk("R8 none qualifies stays", sel_idx, 1);
    chk("R8 holdover when none", holdover_req, 1);

    wr(2'd3, 8'd5);
    clk_present = 4'b1010;
    wr(2'd0, 8'h02);
    step(2);
    chk("R10 no better input", sel_idx, 1);
    clk_present = 4'b1011;
    step(5);
    chk("R10 not yet qualified", sel_idx, 1);
    step(1);
    chk("R10 revert after N+1 edges", sel_idx, 0);
    chk("R10 revert pulse", sel_change, 1);

    done = 1;
    finish_run();
  end
endmodule